// File: doc/BRIEF.md
# One-Wire Search Triplet Sequencer

This block runs one step of a one-wire ROM search. A start pulse carries the direction the search loop would like to take at the current bit position. The block then runs three single-bit transfers on a slot engine: it reads the identity bit, reads its complement, and writes back the branch direction it has chosen. It reports the outcome as a 3-bit code together with a one-cycle done pulse.

The slot engine sits behind two request/acknowledge pairs, one for read slots and one for write slots. Slot timing and the 64-step loop around the triplet are handled elsewhere. The block makes the branch decision and sequences the three transfers. It also bounds each transfer with a cycle timeout. When a transfer times out, the step is abandoned and the block drops out of single-bit operation.

Top module: `ow_trip_seq`

## Requirements
- R1: A start pulse sampled while idle latches `dir_i`. The block then issues exactly one read request for the identity bit and then one read request for the complement bit. When a write is due, it follows with one write request. The three requests come strictly in that order.
- R2: If both bits read 1, no slave is present. No write request is issued, done pulses, and `result_o` is 3'b011.
- R3: If both bits read 0, the latched requested direction is driven on `wr_bit_o` during the write. `result_o` is then {dir,0,0}, which is 3'b100 or 3'b000.
- R4: If exactly one bit reads 1, the write drives the identity bit value. `result_o` is then 3'b101 when the identity bit is 1 and 3'b010 when it is 0.
- R5: The result encoding is: bit 0 is the identity bit, bit 1 is the complement bit, bit 2 is the direction taken.
- R6: A request stays high until its acknowledge. After every acknowledge, both requests are low for at least one cycle before the next request starts.
- R7: A request that is not acknowledged within `TIMEOUT_CYCLES` cycles of being raised abandons the sequence. In that case `err_o` pulses together with done, `result_o` is 3'b011, `busy_o` falls, and no further request follows. An acknowledge that arrives in cycle `TIMEOUT_CYCLES` is still accepted.
- R8: `done_o` is a single-cycle pulse. `err_o` is low on a completed step. `result_o` holds its value until the next step finishes.
- R9: A start pulse or a change of `dir_i` while busy has no effect on the running step, and no second step is queued.
- R10: After reset, all requests, `busy_o`, `done_o` and `err_o` are low, and `result_o` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin one triplet step |
| dir_i | input | 1 | Requested branch direction, sampled with start |
| rd_req_o | output | 1 | Read-slot request to the slot engine |
| rd_ack_i | input | 1 | Read-slot complete, one cycle |
| rd_bit_i | input | 1 | Bit sampled in the read slot, valid with rd_ack_i |
| wr_req_o | output | 1 | Write-slot request to the slot engine |
| wr_bit_o | output | 1 | Bit to write, valid while wr_req_o is high |
| wr_ack_i | input | 1 | Write-slot complete, one cycle |
| busy_o | output | 1 | Step in progress (single-bit operation active) |
| done_o | output | 1 | Result valid, one-cycle pulse |
| err_o | output | 1 | Step abandoned on timeout, pulses with done_o |
| result_o | output | 3 | {direction, complement bit, identity bit} |

## Verification
The assertions assume the slot engine raises each acknowledge for only one cycle, and only while the matching request is high. They also assume the read bit is valid in that same cycle. The bench responder meets these assumptions: it counts the cycles a request has been high and pulses the acknowledge once at a chosen latency. Once it has acknowledged, it does not respond again until the request has dropped. A timeout is provoked by muting the responder for one chosen slot, or by setting its latency one cycle past the limit. Both ways keep the acknowledge protocol itself legal.

// File: rtl/ow_trip_pkg.sv
package ow_trip_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ID,
        ST_GAP_A,
        ST_RD_CMP,
        ST_GAP_B,
        ST_WR
    } trip_state_e;

    // returned when no slave answers and when a step is abandoned
    localparam logic [2:0] CODE_NONE = 3'b011;

    typedef struct packed {
        trip_state_e st;
        logic        dir;
        logic        id;
        logic        cmp;
        logic        done;
        logic        err;
        logic [2:0]  res;
    } trip_reg_t;

endpackage

// File: rtl/ow_trip_decide.sv
module ow_trip_decide (
    input  logic       id_i,
    input  logic       cmp_i,
    input  logic       dir_req_i,
    output logic       absent_o,
    output logic       dir_o,
    output logic [2:0] code_o
);
    always_comb begin
        absent_o = id_i & cmp_i;
        if (!id_i && !cmp_i) begin
            dir_o = dir_req_i;   // conflict: follow the loop's choice
        end else begin
            dir_o = id_i;        // only one value present: forced
        end
        if (absent_o) begin
            code_o = ow_trip_pkg::CODE_NONE;
        end else begin
            code_o = {dir_o, cmp_i, id_i};
        end
    end
endmodule

// File: rtl/ow_trip_timer.sv
module ow_trip_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_i,
    output logic expired_o
);
    localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (wait_i && (cnt_q != LAST)) begin
            cnt_d = cnt_q + 1'b1;
        end
        expired_o = wait_i && (cnt_q == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    initial begin
        AST_LIMIT_SANE: assert (LIMIT >= 2); // R7
    end
endmodule

// File: rtl/ow_trip_seq.sv
module ow_trip_seq #(
    parameter int TIMEOUT_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       dir_i,
    output logic       rd_req_o,
    input  logic       rd_ack_i,
    input  logic       rd_bit_i,
    output logic       wr_req_o,
    output logic       wr_bit_o,
    input  logic       wr_ack_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic [2:0] result_o
);
    import ow_trip_pkg::*;

    trip_reg_t r_d, r_q;
    logic      waiting, expired;
    logic      cmp_now, absent, dir_take;
    logic [2:0] code;

    // complement is taken live in the cycle it arrives, latched after
    assign cmp_now = (r_q.st == ST_RD_CMP) ? rd_bit_i : r_q.cmp;

    ow_trip_decide u_decide (
        .id_i      (r_q.id),
        .cmp_i     (cmp_now),
        .dir_req_i (r_q.dir),
        .absent_o  (absent),
        .dir_o     (dir_take),
        .code_o    (code)
    );

    always_comb begin
        waiting = ((r_q.st == ST_RD_ID || r_q.st == ST_RD_CMP) && !rd_ack_i)
               || ((r_q.st == ST_WR) && !wr_ack_i);
    end

    ow_trip_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wait_i    (waiting),
        .expired_o (expired)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st  = ST_RD_ID;
                    r_d.dir = dir_i;
                end
            end
            ST_RD_ID: begin
                if (rd_ack_i) begin
                    r_d.id = rd_bit_i;
                    r_d.st = ST_GAP_A;
                end else if (expired) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                    r_d.res  = CODE_NONE;
                end
            end
            ST_GAP_A: r_d.st = ST_RD_CMP;
            ST_RD_CMP: begin
                if (rd_ack_i) begin
                    r_d.cmp = rd_bit_i;
                    if (absent) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                        r_d.res  = code;
                    end else begin
                        r_d.st = ST_GAP_B;
                    end
                end else if (expired) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                    r_d.res  = CODE_NONE;
                end
            end
            ST_GAP_B: r_d.st = ST_WR;
            ST_WR: begin
                if (wr_ack_i) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.res  = code;
                end else if (expired) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                    r_d.err  = 1'b1;
                    r_d.res  = CODE_NONE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, dir: 1'b0, id: 1'b0, cmp: 1'b0,
                     done: 1'b0, err: 1'b0, res: 3'b000};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_req_o = (r_q.st == ST_RD_ID) || (r_q.st == ST_RD_CMP);
    assign wr_req_o = (r_q.st == ST_WR);
    assign wr_bit_o = dir_take;
    assign busy_o   = (r_q.st != ST_IDLE);
    assign done_o   = r_q.done;
    assign err_o    = r_q.err;
    assign result_o = r_q.res;

    AST_RD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && rd_ack_i |=> !rd_req_o && !wr_req_o); // R6
    AST_WR_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && $past(wr_req_o) |-> $stable(wr_bit_o)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !rd_req_o && !wr_req_o); // R7
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o && result_o == 3'b011); // R7
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !err_o |-> !(result_o[2] && result_o[1])
                          && !(result_o[0] && !result_o[1] && !result_o[2])); // R5
    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req_o, wr_req_o})); // R1
endmodule

// File: tb/ow_trip_seq_tb.sv
module ow_trip_seq_tb;
    localparam int TMO = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, dir_i = 1'b0;
    logic rd_req_o, rd_ack_i = 1'b0, rd_bit_i = 1'b0;
    logic wr_req_o, wr_bit_o, wr_ack_i = 1'b0;
    logic busy_o, done_o, err_o;
    logic [2:0] result_o;

    int n_chk = 0, n_err = 0;
    int rd_lat = 1, wr_lat = 1, mute_rd = -1, mute_wr = 0;
    logic id_v = 1'b0, cmp_v = 1'b0;
    int n_reads = 0, n_writes = 0, done_cnt = 0;
    logic last_wr = 1'b0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [2:0] got_res;
    logic got_err;

    always #5 clk = ~clk;

    ow_trip_seq #(.TIMEOUT_CYCLES(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_i(dir_i),
        .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_bit_i(rd_bit_i),
        .wr_req_o(wr_req_o), .wr_bit_o(wr_bit_o), .wr_ack_i(wr_ack_i),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .result_o(result_o)
    );

    // slot engine model
    initial begin
        forever begin
            @(negedge clk);
            rd_ack_i = 1'b0;
            wr_ack_i = 1'b0;
            if (rd_req_o) begin
                rd_cnt++;
                if (rd_cnt == rd_lat && mute_rd != n_reads) begin
                    rd_ack_i = 1'b1;
                    rd_bit_i = (n_reads == 0) ? id_v : cmp_v;
                    n_reads++;
                end
            end else rd_cnt = 0;
            if (wr_req_o) begin
                wr_cnt++;
                if (wr_cnt == wr_lat && mute_wr == 0) begin
                    wr_ack_i = 1'b1;
                    last_wr  = wr_bit_o;
                    n_writes++;
                end
            end else wr_cnt = 0;
            if (done_o) done_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done();
        for (int k = 0; k < 400; k++) begin
            if (done_o) break;
            @(negedge clk);
        end
        got_res = result_o;
        got_err = err_o;
    endtask

    task automatic launch(input logic id, input logic cmp, input logic dir);
        id_v = id; cmp_v = cmp;
        n_reads = 0; n_writes = 0; done_cnt = 0;
        @(negedge clk);
        start_i = 1'b1; dir_i = dir;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic exp_dir;
        int exp_code, exp_w;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 rd_req", rd_req_o, 0);
        chk("R10 wr_req", wr_req_o, 0);
        chk("R10 busy", busy_o, 0);
        chk("R10 done", done_o, 0);
        chk("R10 err", err_o, 0);
        chk("R10 result", result_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // exhaustive sweep over bit pair, direction and latency
        for (int lat = 1; lat <= 3; lat++) begin
            for (int v = 0; v < 8; v++) begin
                logic id, cmp, dir;
                id = v[0]; cmp = v[1]; dir = v[2];
                rd_lat = lat; wr_lat = 4 - lat;
                launch(id, cmp, dir);
                wait_done();
                if (id && cmp) begin
                    exp_code = 3; exp_w = 0; exp_dir = 1'b0;  // R2
                end else begin
                    exp_dir  = (!id && !cmp) ? dir : id;      // R3 R4
                    exp_code = 4 * exp_dir + 2 * cmp + id;    // R5
                    exp_w    = 1;
                end
                chk("R5 result", got_res, exp_code);
                chk("R8 err low", got_err, 0);
                chk("R1 reads", n_reads, 2);
                chk("R2 writes", n_writes, exp_w);
                if (exp_w == 1) chk("R3/R4 wr bit", last_wr, exp_dir);
                repeat (3) @(negedge clk);
                chk("R8 single done", done_cnt, 1);
                chk("R8 result held", result_o, exp_code);
                chk("R8 busy low", busy_o, 0);
            end
        end

        // R7 timeout on each slot
        rd_lat = 2; wr_lat = 2;
        for (int s = 0; s < 3; s++) begin
            if (s < 2) mute_rd = s; else mute_wr = 1;
            launch(1'b0, 1'b1, 1'b0);
            wait_done();
            chk("R7 err", got_err, 1);
            chk("R7 code", got_res, 3);
            chk("R7 reads", n_reads, (s < 2) ? s : 2);
            repeat (4) @(negedge clk);
            chk("R7 no req after abort", rd_req_o | wr_req_o | busy_o, 0);
            chk("R7 single done", done_cnt, 1);
            chk("R7 writes", n_writes, 0);
            mute_rd = -1; mute_wr = 0;
        end

        // R7 boundary: ack at the last allowed cycle accepted, one later not
        rd_lat = TMO; wr_lat = TMO;
        launch(1'b1, 1'b0, 1'b0);
        wait_done();
        chk("R7 edge accepted err", got_err, 0);
        chk("R7 edge accepted code", got_res, 5);
        repeat (2) @(negedge clk);
        rd_lat = TMO + 1;
        launch(1'b1, 1'b0, 1'b0);
        wait_done();
        chk("R7 edge late err", got_err, 1);
        chk("R7 edge late reads", n_reads, 0);
        repeat (2) @(negedge clk);

        // R9 start and dir ignored while busy
        rd_lat = 3; wr_lat = 3;
        launch(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        start_i = 1'b1; dir_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        chk("R9 result", got_res, 0);
        chk("R9 wr bit", last_wr, 0);
        repeat (4) @(negedge clk);
        chk("R9 reads", n_reads, 2);
        chk("R9 single done", done_cnt, 1);
        chk("R9 no queued step", busy_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule